// File: doc/BRIEF.md
# Chainable Crosspoint Routing Control

This block holds the routing state of a 16-output, 16-input switching matrix and the serial port that loads it. For every output the active latches keep a 4-bit input select, a gain bit and an enable bit. A host shifts configuration bits in over a four-wire serial port: a serial clock, a data input, an active-low frame select and a data output for chaining. A separate update strobe then copies the loaded data into the active latches. Several devices can share one serial chain. Each device passes the bits it pushes out of its far end to the next device in the chain.

Two frame formats exist, and the number of serial clocks in the frame decides which one is used. A long frame fills the 96-bit matrix register with all sixteen output fields. A frame of exactly 16 clocks carries one output address together with that output's settings, and it leaves the retained matrix register alone.

An asynchronous active-low reset turns every output off and leaves the select and gain fields as they were. After reset, a bare update strobe with no new long frame reloads the retained matrix, so the settings in force before the reset come back. All serial inputs are sampled by a system clock that runs well faster than the serial clock.

Top module: `xpoint_ctrl`

## Requirements
- R1: After a long frame and an update strobe, output o takes its field from bits [6o+5:6o] of the last 96 bits shifted, sent most significant bit first so that output 15 arrives first: input select in [6o+5:6o+2], gain in bit 6o+1 (0 = unity, 1 = double), enable in bit 6o.
- R2: Shifting a frame does not change the select, gain or enable outputs. They change only on a cycle where the update strobe is high.
- R3: A bit is taken only on a rising serial-clock edge while the frame select is low. Serial-clock edges while the frame select is high are ignored and do not move the register.
- R4: The chaining output presents, after each accepted edge, the bit that left the far end of the 96-bit register on that edge. When 2×96 bits are shifted through one device, the device keeps the last 96 bits and emits the first 96 bits in order.
- R5: A frame of exactly 16 clocks is a single-output word, most significant bit first: output address in [15:12], input select in [11:8], gain in bit 7, enable in bit 6, bits [5:0] ignored. An update then changes only the addressed output.
- R6: A 16-clock frame leaves the retained 96-bit matrix contents unchanged.
- R7: While reset is low, every enable output is 0. Select and gain outputs keep their values.
- R8: After reset is released, the enables stay 0 until an update strobe.
- R9: An update strobe after reset, with no long frame since reset, restores all fields from the retained matrix register.
- R10: An update strobe in a cycle where reset is low has no effect.
- R11: A frame whose clock count is neither 0 nor 16 is a long frame and commits the last 96 bits shifted. A frame with zero clocks changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all other inputs |
| rst_n | input | 1 | Active-low reset; clears enables asynchronously |
| sclk | input | 1 | Serial clock, synchronous to clk, slower than clk |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select; rising edge ends a frame |
| upd | input | 1 | Update strobe copying loaded data into the latches |
| sdo | output | 1 | Serial data out for the next device in the chain |
| out_sel | output | 64 | Input select per output, output o at [4o+3:4o] |
| out_gain | output | 16 | Gain bit per output |
| out_en | output | 16 | Enable bit per output |

## Verification
Reset and the update strobe can land in the same system-clock cycle. The bench provokes this by loading a new long frame that has not yet been applied, then raising the strobe on the same edge where reset falls. After release it judges that the enables are still off and that the select fields still hold the old values instead of the new frame's. A later bare strobe must then bring in the new frame. The same pairing appears on the short-word path: a reset that follows a sweep of single-output updates has to drop the pending short word, so that the next strobe reloads the retained matrix and not the last addressed output.

// File: rtl/xp_pkg.sv
// Shared sizing for the crosspoint control block.
// Assumes a fixed field order inside each per-output slot: select, gain, enable.
package xp_pkg;
    localparam int XP_NOUT   = 16;  // outputs of the matrix
    localparam int XP_SELW   = 4;   // input-select width
    localparam int XP_SHORTW = 16;  // clocks in a single-output frame
    localparam int XP_FLDW   = XP_SELW + 2;
    localparam int XP_FULLW  = XP_NOUT * XP_FLDW;
endpackage

// File: rtl/xp_serial_front.sv
// Serial front end: detects serial-clock rises and frame ends on the system
// clock, shifts data into a working register, counts clocks per frame and
// drives the chaining output. Assumes sclk, sdi and cs_n are already
// synchronous to clk and that each sclk level lasts at least one clk cycle.
module xp_serial_front #(
    parameter int FULLW = 96,
    parameter int CNTW  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             cs_n,
    output logic [FULLW-1:0] work,
    output logic             sdo,
    output logic             frame_end,
    output logic [CNTW-1:0]  frame_cnt
);
    localparam logic [CNTW-1:0] CNT_MAX = '1;

    logic            sclk_q;
    logic            cs_q;
    logic [CNTW-1:0] cnt_q;
    logic            shift_ev;

    assign shift_ev  = sclk && !sclk_q && !cs_n;
    assign frame_end = cs_n && !cs_q;
    assign frame_cnt = cnt_q;

    // Edge-detect history for the serial clock and the frame select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // Saturating count of accepted clocks in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (frame_end) begin
            cnt_q <= '0;
        end else if (shift_ev && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Working shift register; kept through reset so nothing is lost.
    always_ff @(posedge clk) begin
        if (shift_ev) begin
            work <= {work[FULLW-2:0], sdi};
        end
    end

    // Chaining output: the bit leaving the far end on each accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b0;
        end else if (shift_ev) begin
            sdo <= work[FULLW-1];
        end
    end

    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(work)) else $error("work moved while deselected"); // R3

endmodule

// File: rtl/xp_frame_store.sv
// Frame store: at each frame end, sorts the frame by its clock count. A long
// frame commits the working register to the retained matrix register. A
// 16-clock frame keeps the address and settings bits and marks a short word
// pending. A frame with zero clocks is dropped. Reset clears only the
// pending mark.
module xp_frame_store #(
    parameter int FULLW  = 96,
    parameter int SHORTW = 16,
    parameter int KEEPW  = 10,
    parameter int CNTW   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic [CNTW-1:0]  frame_cnt,
    input  logic [FULLW-1:0] work,
    output logic [FULLW-1:0] kept,
    output logic [KEEPW-1:0] short_word,
    output logic             short_pend
);
    localparam logic [CNTW-1:0] CNT_SHORT = CNTW'(SHORTW);

    logic is_short;
    logic is_full;

    assign is_short = frame_end && (frame_cnt == CNT_SHORT);
    assign is_full  = frame_end && (frame_cnt != '0) && (frame_cnt != CNT_SHORT);

    // Retained matrix register; only a long frame replaces it.
    always_ff @(posedge clk) begin
        if (is_full) begin
            kept <= work;
        end
    end

    // Used part of the last single-output word.
    always_ff @(posedge clk) begin
        if (is_short) begin
            short_word <= work[SHORTW-1 -: KEEPW];
        end
    end

    // Selects which source the next update strobe applies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_pend <= 1'b0;
        end else if (is_short) begin
            short_pend <= 1'b1;
        end else if (is_full) begin
            short_pend <= 1'b0;
        end
    end

    AST_SHORT_KEEPS_MATRIX: assert property (@(posedge clk) disable iff (!rst_n)
        is_short |=> $stable(kept)) else $error("short frame touched matrix"); // R6
    AST_EMPTY_FRAME_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && frame_cnt == '0) |=> ($stable(kept) && $stable(short_pend)))
        else $error("empty frame changed state"); // R11

endmodule

// File: rtl/xp_route_latch.sv
// Active routing latches: one select, gain and enable per output. On an
// update strobe they load either the whole retained matrix or only the
// output named by a pending short word. Enables clear asynchronously on
// reset. Select and gain have no reset, and an update while reset is low
// is ignored.
module xp_route_latch #(
    parameter int NOUT  = 16,
    parameter int SELW  = 4,
    parameter int FULLW = 96,
    parameter int ADRW  = 4,
    parameter int KEEPW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic [FULLW-1:0]     kept,
    input  logic [KEEPW-1:0]     short_word,
    input  logic                 short_pend,
    output logic [NOUT*SELW-1:0] sel_o,
    output logic [NOUT-1:0]      gain_o,
    output logic [NOUT-1:0]      en_o
);
    localparam int FLDW = SELW + 2;

    logic [ADRW-1:0] s_adr;
    logic [SELW-1:0] s_sel;
    logic            s_gain;
    logic            s_en;

    assign s_adr  = short_word[KEEPW-1 -: ADRW];
    assign s_sel  = short_word[KEEPW-ADRW-1 -: SELW];
    assign s_gain = short_word[1];
    assign s_en   = short_word[0];

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        logic            hit;
        logic [SELW-1:0] sel_q;
        logic            gain_q;
        logic            en_q;

        assign hit = short_pend ? (s_adr == ADRW'(o)) : 1'b1;

        // Select and gain load on update; held through reset.
        always_ff @(posedge clk) begin
            if (upd && rst_n && hit) begin
                sel_q  <= short_pend ? s_sel  : kept[o*FLDW+2 +: SELW];
                gain_q <= short_pend ? s_gain : kept[o*FLDW+1];
            end
        end

        // Enable loads on update and clears at once on reset.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q <= 1'b0;
            end else if (upd && hit) begin
                en_q <= short_pend ? s_en : kept[o*FLDW];
            end
        end

        assign sel_o[o*SELW +: SELW] = sel_q;
        assign gain_o[o]             = gain_q;
        assign en_o[o]               = en_q;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_EN_OFF_IN_RESET: assert (en_o == '0) else $error("enable on in reset"); // R7
        end
    end
    AST_EN_OFF_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_o == '0)) else $error("enable on at release"); // R8
    AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(sel_o) && $stable(gain_o) && $stable(en_o)))
        else $error("latch moved without update"); // R2
    AST_SHORT_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && short_pend) |=> ($countones(en_o ^ $past(en_o)) <= 1))
        else $error("short word moved several enables"); // R5

endmodule

// File: rtl/xpoint_ctrl.sv
// Top of the crosspoint control block: serial front end, frame store and
// active routing latches. Assumes all inputs are synchronous to clk and
// that the serial clock is at most half the rate of clk.
module xpoint_ctrl
    import xp_pkg::*;
#(
    parameter int NOUT   = XP_NOUT,
    parameter int SELW   = XP_SELW,
    parameter int SHORTW = XP_SHORTW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 sdi,
    input  logic                 cs_n,
    input  logic                 upd,
    output logic                 sdo,
    output logic [NOUT*SELW-1:0] out_sel,
    output logic [NOUT-1:0]      out_gain,
    output logic [NOUT-1:0]      out_en
);
    localparam int FULLW = NOUT * (SELW + 2);
    localparam int ADRW  = $clog2(NOUT);
    localparam int KEEPW = ADRW + SELW + 2;
    localparam int CNTW  = $clog2(FULLW + 1);

    logic [FULLW-1:0] work;
    logic [FULLW-1:0] kept;
    logic [KEEPW-1:0] short_word;
    logic             short_pend;
    logic             frame_end;
    logic [CNTW-1:0]  frame_cnt;

    xp_serial_front #(.FULLW(FULLW), .CNTW(CNTW)) u_front (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .work(work), .sdo(sdo), .frame_end(frame_end), .frame_cnt(frame_cnt)
    );

    xp_frame_store #(.FULLW(FULLW), .SHORTW(SHORTW), .KEEPW(KEEPW), .CNTW(CNTW)) u_store (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .frame_cnt(frame_cnt),
        .work(work), .kept(kept), .short_word(short_word), .short_pend(short_pend)
    );

    xp_route_latch #(.NOUT(NOUT), .SELW(SELW), .FULLW(FULLW), .ADRW(ADRW), .KEEPW(KEEPW)) u_latch (
        .clk(clk), .rst_n(rst_n), .upd(upd), .kept(kept), .short_word(short_word),
        .short_pend(short_pend), .sel_o(out_sel), .gain_o(out_gain), .en_o(out_en)
    );

endmodule

// File: tb/xpoint_ctrl_bench.sv
module xpoint_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        cs_n = 1'b1;
    logic        upd = 1'b0;
    logic        sdo;
    logic [63:0] out_sel;
    logic [15:0] out_gain;
    logic [15:0] out_en;

    int total = 0;
    int bad = 0;

    logic [63:0] e_sel;
    logic [15:0] e_gain;
    logic [15:0] e_en;

    xpoint_ctrl u_xpoint_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .upd(upd),
        .sdo(sdo), .out_sel(out_sel), .out_gain(out_gain), .out_en(out_en)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " sel"}, out_sel, e_sel);
        chk({tag, " gain"}, {48'd0, out_gain}, {48'd0, e_gain});
        chk({tag, " en"}, {48'd0, out_en}, {48'd0, e_en});
    endtask

    // Builds a 96-bit matrix word and the outputs it should produce.
    task automatic mk_word(input int seed, output logic [95:0] w,
                           output logic [63:0] s, output logic [15:0] g, output logic [15:0] e);
        w = '0; s = '0; g = '0; e = '0;
        for (int o = 0; o < 16; o++) begin
            logic [3:0] sv;
            logic       gv;
            logic       ev;
            sv = 4'((o * seed + 3 * seed + 1) % 16);
            gv = 1'((o + seed) % 2);
            ev = ((o + seed) % 3) != 0;
            w[o*6 +: 6] = {sv, gv, ev};
            s[o*4 +: 4] = sv;
            g[o] = gv;
            e[o] = ev;
        end
    endtask

    // Shifts n bits MSB first in one frame; optionally checks the chain output.
    task automatic frame(input logic [191:0] d, input int n,
                         input logic [95:0] cw, input int cfrom, input string tag);
        @(negedge clk);
        cs_n = 1'b0;
        for (int k = 1; k <= n; k++) begin
            sdi = d[n-k];
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            if (cfrom > 0 && k >= cfrom && k < cfrom + 96)
                chk(tag, {63'd0, sdo}, {63'd0, cw[95-(k-cfrom)]});
        end
        sclk = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_upd;
        @(negedge clk);
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle_clocks(input int n);
        for (int k = 0; k < n; k++) begin
            sdi = k[0];
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [95:0] wa, wb, wc, base;
        logic [63:0] s2;
        logic [15:0] g2, e2;

        #2 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 enables off in reset", {48'd0, out_en}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 enables off after release", {48'd0, out_en}, 64'd0);

        // R1/R2: several long frames.
        for (int seed = 1; seed <= 5; seed++) begin
            logic [63:0] ps;
            logic [15:0] pe;
            ps = out_sel;
            pe = out_en;
            mk_word(seed, wa, e_sel, e_gain, e_en);
            frame({96'd0, wa}, 96, '0, 0, "");
            chk("R2 sel held before update", out_sel, ps);
            chk("R2 en held before update", {48'd0, out_en}, {48'd0, pe});
            pulse_upd();
            chk_all("R1 full load");
        end

        // R11: a 100-clock frame keeps its last 96 bits.
        mk_word(7, wa, e_sel, e_gain, e_en);
        frame({92'd0, 4'b1011, wa}, 100, '0, 0, "");
        pulse_upd();
        chk_all("R11 long frame of 100 clocks");

        // R3/R4: clocks with cs_n high are ignored; chain output shows the old word.
        mk_word(9, wb, s2, g2, e2);
        idle_clocks(10);
        frame({96'd0, wb}, 96, wa, 1, "R3 R4 chain output after idle clocks");
        e_sel = s2; e_gain = g2; e_en = e2;
        pulse_upd();
        chk_all("R3 frame after idle clocks");

        // R4: a 192-bit chain; this device keeps the second word.
        mk_word(11, wc, s2, g2, e2);
        mk_word(13, wa, e_sel, e_gain, e_en);
        frame({wc, wa}, 192, wc, 97, "R4 chained bits emitted");
        pulse_upd();
        chk_all("R4 last word kept");
        base = wa;

        // R5/R2: sweep every output address with a single-output word.
        for (int a = 0; a < 16; a++) begin
            logic [3:0] sv;
            logic       gv, ev;
            sv = ~4'(a);
            gv = ~e_gain[a];
            ev = ~e_en[a];
            frame({176'd0, 4'(a), sv, gv, ev, 6'b101101}, 16, '0, 0, "");
            chk("R2 short frame before update", out_sel, e_sel);
            e_sel[a*4 +: 4] = sv;
            e_gain[a] = gv;
            e_en[a] = ev;
            pulse_upd();
            chk_all("R5 single-output update");
        end

        // R11: an empty frame keeps a pending short word.
        frame({176'd0, 4'd3, 4'd6, 1'b1, 1'b1, 6'd0}, 16, '0, 0, "");
        frame('0, 0, '0, 0, "");
        e_sel[12 +: 4] = 4'd6; e_gain[3] = 1'b1; e_en[3] = 1'b1;
        pulse_upd();
        chk_all("R11 empty frame inert");

        // R7/R6/R9: reset, then a bare update restores the retained matrix.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 sel kept in reset", out_sel, e_sel);
        chk("R7 enables cleared", {48'd0, out_en}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 enables stay off", {48'd0, out_en}, 64'd0);
        mk_word(13, base, e_sel, e_gain, e_en);
        pulse_upd();
        chk_all("R6 R9 restore after reset");

        // R10: reset and update in the same cycle.
        mk_word(4, wa, s2, g2, e2);
        frame({96'd0, wa}, 96, '0, 0, "");
        @(negedge clk);
        rst_n = 1'b0;
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 sel unchanged", out_sel, e_sel);
        chk("R10 enables off", {48'd0, out_en}, 64'd0);
        e_sel = s2; e_gain = g2; e_en = e2;
        pulse_upd();
        chk_all("R10 later update applies");

        finish_run();
    end
endmodule